// File: doc/BRIEF.md
# Prefetching APB Register Slave

This block is an APB completer in front of a small bank of word-wide registers. In the cycle where the requester shows a new transfer (select high, enable low), the block latches the address and the read/write direction on the closing clock edge. The register lookup starts from that same address, so the read value is already held in the output register when the access phase begins. Write data is taken during the access phase and stored on the edge that completes the transfer.

A parameter selects the response timing. With `WAIT_STATES = 0`, ready is tied high and every transfer takes two clocks. With `WAIT_STATES = N > 0`, ready stays low for N access cycles and then rises for one cycle. In that case the read value is loaded from the latched address on the edge that enters the ready cycle, which models a slow read source. The error response is tied low.

The controller has three states. `ST_IDLE` waits for a setup cycle. `ST_WAIT` counts the wait states. `ST_READY` is the completing access cycle. The transitions are:
- IDLE→READY on setup with no wait states.
- IDLE→WAIT on setup with wait states.
- WAIT→WAIT while the count is nonzero.
- WAIT→READY when the count reaches zero.
- WAIT→IDLE if select drops.
- READY→IDLE always.

Because READY→IDLE always happens, the next cycle can already be a new setup cycle.

Top module: `apb_prefetch_regs`

## Requirements
- R1: An active-low reset clears every register, the latched address and direction, and the read data output to zero.
- R2: Address and direction are latched only on the edge ending a setup cycle (select high, enable low). Changing `paddr` or `pwrite` during the access phase has no effect on the transfer.
- R3: A write stores the `pwdata` value present in the access phase, on the edge where select, enable and ready are all high.
- R4: With `WAIT_STATES = 0`, `pready` is high at all times. Every transfer completes in exactly two clocks, and the read value is valid in the first access cycle.
- R5: With `WAIT_STATES = N > 0`, the first N access cycles show `pready` low. The next cycle shows `pready` high for exactly one cycle, with valid read data, so a transfer takes N+2 clocks.
- R6: `prdata` changes only when a read loads it. It holds through write transfers and idle cycles.
- R7: The register index is `paddr[5:2]` for the default 16 entries (byte address = 4 × index; bits [1:0] are ignored). An address with any bit above the index field set is outside the bank: it reads as zero, its writes change no register, and `pslverr` stays low.
- R8: A new setup cycle may follow a completing access cycle directly, with no idle cycle, and both transfers behave as if isolated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Registered read data |
| pready | output | 1 | Transfer completes when high |
| pslverr | output | 1 | Error response, always low |

## Verification
The assertions check the following on every clock:
- the reset value of the read output;
- that the latched address stays fixed while a transfer is stalled;
- that read data does not move during write transfers;
- the ready pattern after each setup cycle;
- the bound on consecutive wait cycles;
- that the ready pulse lasts one cycle;
- that the error output stays low.

Only the bench scenarios can show data correctness:
- that writes land in the register the decode selects;
- that out-of-range writes leave the bank untouched;
- that access-phase changes to address and direction are ignored;
- that back-to-back transfers keep their values apart;
- that the exact cycle counts hold in both timing modes.

// File: rtl/prf_pkg.sv
package prf_pkg;

    // Controller states of the completer
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_READY = 2'd2
    } prf_state_e;

endpackage

// File: rtl/prf_ctrl.sv
module prf_ctrl
    import prf_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int WAIT_STATES = 0
) (
    input  logic              clk,
    input  logic              rstn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output prf_state_e        state_o,
    output logic [ADDR_W-1:0] cap_addr_o,
    output logic              cap_wr_o,
    output logic              pready_o,
    output logic              wr_en_o,
    output logic              rd_load_o,
    output logic [ADDR_W-1:0] rd_addr_o
);

    localparam int CNT_W    = (WAIT_STATES < 2) ? 1 : $clog2(WAIT_STATES);
    localparam int CNT_LOAD = (WAIT_STATES > 0) ? WAIT_STATES - 1 : 0;
    localparam bit NO_WAIT  = (WAIT_STATES == 0);

    prf_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] cap_addr_q;
    logic              cap_wr_q;
    logic              setup_seen;
    logic              ready_st;

    assign setup_seen = psel && !penable;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (setup_seen) begin
                    state_d = NO_WAIT ? ST_READY : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (!psel) begin
                    state_d = ST_IDLE;
                end else if (cnt_q == '0) begin
                    state_d = ST_READY;
                end
            end
            ST_READY: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register, wait counter and request capture
    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            cap_addr_q <= '0;
            cap_wr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && setup_seen) begin
                cap_addr_q <= paddr;
                cap_wr_q   <= pwrite;
                cnt_q      <= CNT_W'(CNT_LOAD);
            end else if (state_q == ST_WAIT && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Per-state outputs
    always_comb begin
        wr_en_o   = 1'b0;
        rd_load_o = 1'b0;
        rd_addr_o = cap_addr_q;
        ready_st  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                // prefetch straight from the bus when no wait states are used
                rd_addr_o = paddr;
                rd_load_o = NO_WAIT && setup_seen && !pwrite;
            end
            ST_WAIT: begin
                rd_load_o = psel && (cnt_q == '0) && !cap_wr_q;
            end
            ST_READY: begin
                ready_st = 1'b1;
                wr_en_o  = psel && penable && cap_wr_q;
            end
            default: begin
                ready_st = 1'b0;
            end
        endcase
    end

    generate
        if (WAIT_STATES == 0) begin : g_zero_wait
            assign pready_o = 1'b1;
        end else begin : g_wait
            assign pready_o = ready_st;
        end
    endgenerate

    assign state_o    = state_q;
    assign cap_addr_o = cap_addr_q;
    assign cap_wr_o   = cap_wr_q;

endmodule

// File: rtl/prf_regbank.sv
module prf_regbank #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    parameter int ADDR_W   = 12
) (
    input  logic              clk,
    input  logic              rstn,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_load,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int IDX_LSB = 2;
    localparam int TOP_LSB = IDX_W + IDX_LSB;

    logic [DATA_W-1:0] regs [NUM_REGS];
    logic [IDX_W-1:0]  rd_idx, wr_idx;
    logic              rd_hit, wr_hit;
    logic [DATA_W-1:0] rd_value;
    logic [DATA_W-1:0] rd_q;

    function automatic logic in_bank(input logic [ADDR_W-1:0] a);
        return (a[ADDR_W-1:TOP_LSB] == '0) &&
               (int'(a[TOP_LSB-1:IDX_LSB]) < NUM_REGS);
    endfunction

    assign rd_idx = rd_addr[TOP_LSB-1:IDX_LSB];
    assign wr_idx = wr_addr[TOP_LSB-1:IDX_LSB];
    assign rd_hit = in_bank(rd_addr);
    assign wr_hit = in_bank(wr_addr);

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk or negedge rstn) begin
                if (!rstn) begin
                    regs[g] <= '0;
                end else if (wr_en && wr_hit && wr_idx == IDX_W'(g)) begin
                    regs[g] <= wr_data;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_value = '0;
        if (rd_hit) begin
            rd_value = regs[rd_idx];
        end
    end

    always_ff @(posedge clk or negedge rstn) begin
        if (!rstn) begin
            rd_q <= '0;
        end else if (rd_load) begin
            rd_q <= rd_value;
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/apb_prefetch_regs.sv
module apb_prefetch_regs
    import prf_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int NUM_REGS    = 16,
    parameter int ADDR_W      = 12,
    parameter int WAIT_STATES = 0
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr
);

    prf_state_e        state;
    logic [ADDR_W-1:0] cap_addr;
    logic              cap_wr;
    logic              wr_en;
    logic              rd_load;
    logic [ADDR_W-1:0] rd_addr;

    prf_ctrl #(
        .ADDR_W      (ADDR_W),
        .WAIT_STATES (WAIT_STATES)
    ) ctrl_i (
        .clk        (pclk),
        .rstn       (presetn),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .state_o    (state),
        .cap_addr_o (cap_addr),
        .cap_wr_o   (cap_wr),
        .pready_o   (pready),
        .wr_en_o    (wr_en),
        .rd_load_o  (rd_load),
        .rd_addr_o  (rd_addr)
    );

    prf_regbank #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) bank_i (
        .clk     (pclk),
        .rstn    (presetn),
        .rd_addr (rd_addr),
        .rd_load (rd_load),
        .wr_addr (cap_addr),
        .wr_en   (wr_en),
        .wr_data (pwdata),
        .rd_data (prdata)
    );

    assign pslverr = 1'b0;

endmodule

// File: rtl/prf_checker.sv
module prf_checker #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 12,
    parameter int WAIT_STATES = 0
) (
    input logic              pclk,
    input logic              presetn,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic              pready,
    input logic              pslverr,
    input logic [DATA_W-1:0] prdata,
    input logic [ADDR_W-1:0] cap_addr,
    input logic              cap_wr
);

    localparam bit HAS_WAIT = (WAIT_STATES > 0);

    // consecutive stalled access cycles
    logic [15:0] low_run;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            low_run <= '0;
        end else if (psel && penable && !pready) begin
            low_run <= low_run + 1'b1;
        end else begin
            low_run <= '0;
        end
    end

    AST_RESET_CLEARS_RDATA: assert property (@(posedge pclk) !presetn |=> prdata == '0); // R1

    AST_ADDR_HELD_IN_STALL: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && !pready) |=> $stable(cap_addr)); // R2

    AST_SETUP_READY_PATTERN: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !penable) |=> (pready == !HAS_WAIT)); // R4

    AST_WAIT_RUN_BOUND: assert property (@(posedge pclk) disable iff (!presetn)
        int'(low_run) <= WAIT_STATES); // R5

    AST_READY_ONE_CYCLE: assert property (@(posedge pclk) disable iff (!presetn)
        (HAS_WAIT && pready) |=> !pready); // R5

    AST_RDATA_HOLD_WR_SETUP: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && !penable && pwrite) |=> $stable(prdata)); // R6

    AST_RDATA_HOLD_WR_ACCESS: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && cap_wr) |=> $stable(prdata)); // R6

    AST_NO_ERROR_RESP: assert property (@(posedge pclk) disable iff (!presetn)
        !pslverr); // R7

endmodule

bind apb_prefetch_regs prf_checker #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .WAIT_STATES (WAIT_STATES)
) chk_i (
    .pclk     (pclk),
    .presetn  (presetn),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .pready   (pready),
    .pslverr  (pslverr),
    .prdata   (prdata),
    .cap_addr (cap_addr),
    .cap_wr   (cap_wr)
);

// File: tb/apb_prefetch_regs_tb_top.sv
module apb_prefetch_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int SLOW_WAITS = 3;
    localparam int NREG       = 16;

    logic        clk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel_f = 1'b0, psel_s = 1'b0;
    logic        penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata_f, prdata_s;
    logic        pready_f, pready_s, pslverr_f, pslverr_s;

    int checks = 0;
    int errors = 0;
    logic [31:0] model_f [NREG];
    logic [31:0] model_s [NREG];

    always #(CLK_PERIOD / 2) clk = ~clk;

    apb_prefetch_regs dut_i (
        .pclk(clk), .presetn(presetn), .psel(psel_f), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata_f), .pready(pready_f), .pslverr(pslverr_f)
    );

    apb_prefetch_regs #(.WAIT_STATES(SLOW_WAITS)) dut_slow_i (
        .pclk(clk), .presetn(presetn), .psel(psel_s), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata_s), .pready(pready_s), .pslverr(pslverr_s)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One transfer, starting and ending at a falling edge; no idle appended.
    task automatic xfer(input bit slow, input bit wr, input logic [11:0] a, input logic [31:0] d,
                        input bit acc_wr, input logic [11:0] acc_a, input logic [31:0] acc_d,
                        output logic [31:0] rd, output int cyc);
        psel_f = !slow; psel_s = slow;
        penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        cyc = 1;
        @(negedge clk);
        penable = 1'b1; pwrite = acc_wr; paddr = acc_a; pwdata = acc_d;
        cyc++;
        while (!(slow ? pready_s : pready_f)) begin
            @(negedge clk);
            cyc++;
        end
        rd = slow ? prdata_s : prdata_f;
        @(negedge clk);
    endtask

    task automatic idle();
        psel_f = 1'b0; psel_s = 1'b0; penable = 1'b0;
        @(negedge clk);
    endtask

    function automatic int idx_of(input logic [11:0] a);
        return int'(a[5:2]);
    endfunction

    function automatic bit in_bank(input logic [11:0] a);
        return a[11:6] == '0;
    endfunction

    task automatic wr32(input bit slow, input logic [11:0] a, input logic [31:0] d, input int exp_cyc);
        logic [31:0] rd;
        int cyc;
        xfer(slow, 1'b1, a, d, 1'b1, a, d, rd, cyc);
        if (in_bank(a)) begin
            if (slow) model_s[idx_of(a)] = d; else model_f[idx_of(a)] = d;
        end
        check(slow ? "R5 write cycles" : "R4 write cycles", cyc, exp_cyc);
    endtask

    task automatic rd32(input bit slow, input logic [11:0] a, input int exp_cyc, input string req);
        logic [31:0] rd, exp;
        int cyc;
        xfer(slow, 1'b0, a, '0, 1'b0, a, '0, rd, cyc);
        exp = !in_bank(a) ? 32'h0 : (slow ? model_s[idx_of(a)] : model_f[idx_of(a)]);
        check(req, rd, exp);
        check(slow ? "R5 read cycles" : "R4 read cycles", cyc, exp_cyc);
    endtask

    task automatic t_after_reset();
        check("R1 prdata fast after reset", prdata_f, 32'h0);
        check("R1 prdata slow after reset", prdata_s, 32'h0);
        check("R4 pready held high", pready_f, 1'b1);
        check("R5 pready low when idle", pready_s, 1'b0);
        for (int i = 0; i < NREG; i++) rd32(1'b0, 12'(i * 4), 2, "R1 register cleared");
        idle();
    endtask

    task automatic t_fast_patterns();
        wr32(1'b0, 12'h000, 32'hFFFF_FFFF, 2); idle();
        wr32(1'b0, 12'h004, 32'hA5A5_5A5A, 2); idle();
        wr32(1'b0, 12'h03C, 32'h1234_5678, 2); idle();
        wr32(1'b0, 12'h020, 32'h0000_0001, 2); idle();
        rd32(1'b0, 12'h000, 2, "R3 readback all ones"); idle();
        rd32(1'b0, 12'h004, 2, "R3 readback alternating"); idle();
        rd32(1'b0, 12'h03C, 2, "R3 readback top entry"); idle();
        rd32(1'b0, 12'h020, 2, "R3 readback single bit"); idle();
    endtask

    task automatic t_index_and_range();
        // R7: low two bits ignored; upper bits select out of bank
        wr32(1'b0, 12'h00B, 32'hCAFE_0002, 2); idle();
        rd32(1'b0, 12'h008, 2, "R7 low bits ignored"); idle();
        wr32(1'b0, 12'h040, 32'hDEAD_BEEF, 2); idle();
        rd32(1'b0, 12'h000, 2, "R7 out-of-bank write ignored"); idle();
        rd32(1'b0, 12'h040, 2, "R7 out-of-bank reads zero"); idle();
        rd32(1'b0, 12'hFFC, 2, "R7 far address reads zero"); idle();
        check("R7 pslverr low", pslverr_f, 1'b0);
    endtask

    task automatic t_capture();
        logic [31:0] rd;
        int cyc;
        // R2/R3: setup says write reg 5; access changes address, direction and data
        xfer(1'b0, 1'b1, 12'h014, 32'h1111_1111, 1'b0, 12'h018, 32'h7777_0005, rd, cyc);
        model_f[5] = 32'h7777_0005;
        idle();
        rd32(1'b0, 12'h014, 2, "R2 latched address and direction used"); idle();
        rd32(1'b0, 12'h018, 2, "R2 access-phase address ignored"); idle();
        rd32(1'b0, 12'h014, 2, "R3 access-phase data stored"); idle();
    endtask

    task automatic t_hold();
        logic [31:0] held;
        held = model_f[1];
        rd32(1'b0, 12'h004, 2, "R6 reference read"); idle();
        wr32(1'b0, 12'h030, 32'h0BAD_F00D, 2);
        check("R6 prdata held across write", prdata_f, held);
        idle(); idle();
        check("R6 prdata held across idle", prdata_f, held);
    endtask

    task automatic t_back_to_back();
        wr32(1'b0, 12'h010, 32'h0101_0101, 2);
        rd32(1'b0, 12'h010, 2, "R8 read after write no idle");
        wr32(1'b0, 12'h014, 32'h0202_0202, 2);
        rd32(1'b0, 12'h010, 2, "R8 neighbour kept");
        rd32(1'b0, 12'h014, 2, "R8 second write seen");
        idle();
    endtask

    task automatic t_slow();
        wr32(1'b1, 12'h008, 32'h5150_0008, SLOW_WAITS + 2); idle();
        rd32(1'b1, 12'h008, SLOW_WAITS + 2, "R5 slow read data"); idle();
        wr32(1'b1, 12'h00C, 32'h5150_000C, SLOW_WAITS + 2);
        rd32(1'b1, 12'h00C, SLOW_WAITS + 2, "R5 slow back-to-back read");
        check("R6 slow prdata after read", prdata_s, 32'h5150_000C);
        idle();
        check("R5 pready low after pulse", pready_s, 1'b0);
    endtask

    task automatic t_mid_reset();
        wr32(1'b0, 12'h024, 32'hFACE_0009, 2);
        rd32(1'b0, 12'h024, 2, "R1 value before reset");
        idle();
        presetn = 1'b0;
        @(negedge clk);
        check("R1 prdata cleared by reset", prdata_f, 32'h0);
        presetn = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NREG; i++) model_f[i] = '0;
        rd32(1'b0, 12'h024, 2, "R1 register cleared by reset"); idle();
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) begin
            model_f[i] = '0;
            model_s[i] = '0;
        end
        repeat (3) @(negedge clk);
        presetn = 1'b1;
        @(negedge clk);
        t_after_reset();
        t_fast_patterns();
        t_index_and_range();
        t_capture();
        t_hold();
        t_back_to_back();
        t_slow();
        t_mid_reset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule